// File: doc/BRIEF.md
# DRAM Refresh Timer and Cycle Arbiter

This block keeps a dynamic RAM array alive and shares it between refresh work and data transfers. A free-running timer, sized from the clock frequency and the refresh period, raises a refresh request at a fixed rate. A row counter names the row to refresh, stepping upward by one after every refresh and wrapping at the top. Each refresh is RAS-only: the row address is driven, RAS is pulled low and CAS stays high.

An arbiter hands the array to one requester at a time. It serves a pending refresh or a pending data cycle, and it drives RAS, CAS and the multiplexed address from its own local timing. A data cycle puts the row on the address pins, lowers RAS, holds the row for a set time, then switches to the column and lowers CAS. Every cycle is followed by a precharge gap. A refresh that falls due while a data cycle owns the array is remembered and served as soon as that cycle ends. No bus handshake signal enters the block. The requester keeps `data_req` high until it sees `data_gnt`.

Top module: `dram_refresh_arbiter`

## Requirements
- R1: While reset is high, and on the first clock after it is asserted, the outputs are idle: `ras_n`=1, `cas_n`=1, `data_gnt`=0 and `mem_addr`=0. The refresh row counter restarts at 0.
- R2: With no data traffic, consecutive refresh cycles start exactly `CLK_KHZ*REFRESH_NS/1_000_000` clocks apart. The timer runs freely from reset.
- R3: A refresh cycle holds `ras_n` low for exactly `RAS_CYC` clocks. During that time `cas_n` stays 1, `data_gnt` stays 0, and `mem_addr` carries the refresh row.
- R4: Refresh rows are 0, 1, 2, ... in order, one step per refresh. After row 2^`ROW_BITS`-1 the next row is 0.
- R5: A data cycle holds `ras_n` low for exactly `RAS_CYC` clocks, with `data_gnt` high for exactly those clocks. For the first `RAH_CYC` clocks `mem_addr` is `data_row` and `cas_n`=1. For the remaining clocks `mem_addr` is `data_col` and `cas_n`=0.
- R6: Between any two cycles `ras_n` stays high for at least `PRE_CYC` clocks.
- R7: A cycle that has started is never cut short. A refresh that falls due during a data cycle is kept pending, not dropped. Under continuous data requests, consecutive refresh starts are never more than interval + `RAS_CYC` + `PRE_CYC` clocks apart.
- R8: When a refresh and a data request are both pending as the arbiter becomes free, the refresh is served first. A refresh therefore starts at most `RAS_CYC`+`PRE_CYC` clocks after its nominal time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_req | input | 1 | Data cycle request, held until `data_gnt` is seen |
| data_row | input | ROW_BITS | Row address of the requested data cycle |
| data_col | input | COL_BITS | Column address of the requested data cycle |
| data_gnt | output | 1 | High while a data cycle owns RAS |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mem_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |

## Verification
The two functions that can meet in one cycle are the expiry of the refresh timer and a data request, both arriving as the arbiter goes idle. The bench first measures the refresh grid with no traffic. It then predicts the next grid point and raises `data_req` two clocks before the expected RAS fall, so that both requests reach the idle arbiter on the same edge. That RAS fall must come with `data_gnt` low, and the data cycle must follow it. A long run of back-to-back requests then slides the timer phase through every point of the data cycle. Each refresh start must stay within the delay bound, and the refresh rows must stay in unbroken order across the wrap.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_ROW,
    ST_COL,
    ST_PRE
  } arb_state_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R2: one tick per period, never two in a row
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_i,
  output logic [ROW_BITS-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst)         row_o <= '0;
    else if (step_i) row_o <= row_o + 1'b1;
  end

  // R4: the top row is followed by row zero
  p_row_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (step_i && (&row_o)) |=> (row_o == '0));

endmodule

// File: rtl/cycle_arbiter.sv
module cycle_arbiter
  import dram_arb_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 9,
  parameter int RAS_CYC  = 4,
  parameter int RAH_CYC  = 1,
  parameter int PRE_CYC  = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  tick_i,
  input  logic                                  data_req_i,
  input  logic [ROW_BITS-1:0]                   data_row_i,
  input  logic [COL_BITS-1:0]                   data_col_i,
  input  logic [ROW_BITS-1:0]                   ref_row_i,
  output logic                                  ref_step_o,
  output logic                                  gnt_o,
  output logic                                  ras_n_o,
  output logic                                  cas_n_o,
  output logic [max_int(ROW_BITS,COL_BITS)-1:0] ma_o
);
  localparam int MA_W    = max_int(ROW_BITS, COL_BITS);
  localparam int COL_LEN = RAS_CYC - RAH_CYC;
  localparam int CW      = $clog2(max_int(RAS_CYC, PRE_CYC) + 1);
  localparam logic [CW-1:0] REF_LOAD = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] ROW_LOAD = CW'(RAH_CYC - 1);
  localparam logic [CW-1:0] COL_LOAD = CW'(COL_LEN - 1);
  localparam logic [CW-1:0] PRE_LOAD = CW'(PRE_CYC - 1);

  arb_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ref_pend_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic take_ref, take_data, last;

  assign last       = (cnt_q == '0);
  assign take_ref   = (state_q == ST_IDLE) && ref_pend_q;
  assign take_data  = (state_q == ST_IDLE) && !ref_pend_q && data_req_i;
  assign ref_step_o = (state_q == ST_REF) && last;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_ref) begin
          state_d = ST_REF;
          cnt_d   = REF_LOAD;
        end else if (take_data) begin
          state_d = ST_ROW;
          cnt_d   = ROW_LOAD;
        end
      end
      ST_REF: begin
        if (last) begin state_d = ST_PRE; cnt_d = PRE_LOAD; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_ROW: begin
        if (last) begin state_d = ST_COL; cnt_d = COL_LOAD; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_COL: begin
        if (last) begin state_d = ST_PRE; cnt_d = PRE_LOAD; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_PRE: begin
        if (last) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ref_pend_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (tick_i)        ref_pend_q <= 1'b1;
      else if (take_ref) ref_pend_q <= 1'b0;
      if (take_data) begin
        row_q <= data_row_i;
        col_q <= data_col_i;
      end
    end
  end

  // Output stage: strobes and address are registered from the state
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      gnt_o   <= 1'b0;
      ma_o    <= '0;
    end else begin
      ras_n_o <= !((state_q == ST_REF) || (state_q == ST_ROW) || (state_q == ST_COL));
      cas_n_o <= (state_q != ST_COL);
      gnt_o   <= (state_q == ST_ROW) || (state_q == ST_COL);
      case (state_q)
        ST_REF:  ma_o <= MA_W'(ref_row_i);
        ST_ROW:  ma_o <= MA_W'(row_q);
        ST_COL:  ma_o <= MA_W'(col_q);
        default: ma_o <= ma_o;
      endcase
    end
  end

  // R8: a pending refresh wins over a data request at an idle arbiter
  p_ref_first_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && ref_pend_q) |=> (state_q == ST_REF));

  // R7: a refresh that is due is held while the array is busy
  p_pend_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_pend_q && state_q != ST_IDLE) |=> ref_pend_q);

  // R7: a data cycle in progress is not abandoned
  p_no_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ROW && !last) |=> (state_q == ST_ROW));

endmodule

// File: rtl/dram_refresh_arbiter.sv
module dram_refresh_arbiter
  import dram_arb_pkg::*;
#(
  parameter int CLK_KHZ    = 50000,
  parameter int REFRESH_NS = 15600,
  parameter int ROW_BITS   = 9,
  parameter int COL_BITS   = 9,
  parameter int RAS_CYC    = 4,
  parameter int RAH_CYC    = 1,
  parameter int PRE_CYC    = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  data_req,
  input  logic [ROW_BITS-1:0]                   data_row,
  input  logic [COL_BITS-1:0]                   data_col,
  output logic                                  data_gnt,
  output logic                                  ras_n,
  output logic                                  cas_n,
  output logic [max_int(ROW_BITS,COL_BITS)-1:0] mem_addr
);
  localparam int INTERVAL = (CLK_KHZ * REFRESH_NS) / 1_000_000;

  logic                tick;
  logic                ref_step;
  logic [ROW_BITS-1:0] ref_row;

  refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  refresh_row_ctr #(.ROW_BITS(ROW_BITS)) u_rows (
    .clk    (clk),
    .rst    (rst),
    .step_i (ref_step),
    .row_o  (ref_row)
  );

  cycle_arbiter #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .RAS_CYC  (RAS_CYC),
    .RAH_CYC  (RAH_CYC),
    .PRE_CYC  (PRE_CYC)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .data_req_i (data_req),
    .data_row_i (data_row),
    .data_col_i (data_col),
    .ref_row_i  (ref_row),
    .ref_step_o (ref_step),
    .gnt_o      (data_gnt),
    .ras_n_o    (ras_n),
    .cas_n_o    (cas_n),
    .ma_o       (mem_addr)
  );

  // Run-length counters for the strobe checks
  logic [7:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= ras_n ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1);
      hi_run <= !ras_n ? 8'd0 : ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1);
    end
  end

  // R3: no CAS during a refresh
  p_ras_only_r3: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && !data_gnt) |-> cas_n);

  // R3 and R5: every RAS pulse lasts the programmed length
  p_ras_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_run == 8'(RAS_CYC)));

  // R5: grant only inside a RAS pulse, CAS only inside a granted pulse
  p_gnt_in_ras_r5: assert property (@(posedge clk) disable iff (rst)
    data_gnt |-> !ras_n);
  p_cas_in_gnt_r5: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> (!ras_n && data_gnt));

  // R5: the column address is steady while CAS is low
  p_col_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n)) |-> $stable(mem_addr));

  // R6: precharge gap before each new RAS pulse
  p_precharge_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_run >= 8'(PRE_CYC)));

endmodule

// File: tb/tb_dram_refresh_arbiter.sv
module tb_dram_refresh_arbiter;
  localparam int CLK_KHZ    = 50000;
  localparam int REFRESH_NS = 420;
  localparam int ROW_BITS   = 9;
  localparam int COL_BITS   = 9;
  localparam int RAS_CYC    = 4;
  localparam int RAH_CYC    = 2;
  localparam int PRE_CYC    = 3;
  localparam int P          = (CLK_KHZ * REFRESH_NS) / 1_000_000;
  localparam int NROWS      = 1 << ROW_BITS;
  localparam int SLACK      = RAS_CYC + PRE_CYC;

  // Stimulus table: {row, col}; the expected address phases equal these
  localparam logic [17:0] VEC [0:7] = '{
    {9'd0,   9'd0},   {9'd511, 9'd511}, {9'd0,   9'd511}, {9'd511, 9'd0},
    {9'h155, 9'h0AA}, {9'h0AA, 9'h155}, {9'd1,   9'd256}, {9'd300, 9'd7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_req = 1'b0;
  logic [ROW_BITS-1:0] data_row = '0;
  logic [COL_BITS-1:0] data_col = '0;
  logic data_gnt, ras_n, cas_n;
  logic [8:0] mem_addr;

  always #10 clk = ~clk;

  dram_refresh_arbiter #(
    .CLK_KHZ(CLK_KHZ), .REFRESH_NS(REFRESH_NS), .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS), .RAS_CYC(RAS_CYC), .RAH_CYC(RAH_CYC), .PRE_CYC(PRE_CYC)
  ) dut (
    .clk(clk), .rst(rst), .data_req(data_req), .data_row(data_row),
    .data_col(data_col), .data_gnt(data_gnt), .ras_n(ras_n), .cas_n(cas_n),
    .mem_addr(mem_addr)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor state
  bit mon_en = 1'b1;
  bit quiet  = 1'b0;
  int cyc, anchor, last_ref, run, hi_len, exp_row, wraps, ref_cnt;
  bit prev_ras, run_ref, bad, seen_run;
  logic [8:0] cur_row, cur_col;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; anchor = -1; last_ref = -1; run = 0; hi_len = 0;
      exp_row = 0; ref_cnt = 0; prev_ras = 1'b1; seen_run = 1'b0; bad = 1'b0;
    end else if (mon_en) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        if (seen_run) chk(hi_len >= PRE_CYC, "R6 precharge gap", hi_len, PRE_CYC);
        seen_run = 1'b1;
        run = 0; bad = 1'b0; run_ref = !data_gnt;
        if (run_ref) begin
          ref_cnt++;
          if (anchor < 0) anchor = cyc;
          else begin
            if (quiet) chk(((cyc - anchor) % P) == 0, "R2 refresh interval", (cyc - anchor) % P, 0);
            chk(((cyc - anchor) % P) <= SLACK, "R8 refresh delay bound", (cyc - anchor) % P, SLACK);
            chk((cyc - last_ref) <= P + SLACK, "R7 refresh not lost", cyc - last_ref, P + SLACK);
          end
          last_ref = cyc;
        end
      end
      if (!ras_n) begin
        run++;
        if (run_ref) begin
          if (!cas_n || data_gnt || mem_addr != 9'(exp_row)) bad = 1'b1;
        end else begin
          if (!data_gnt) bad = 1'b1;
          if (run <= RAH_CYC) begin
            if (!cas_n || mem_addr != cur_row) bad = 1'b1;
          end else begin
            if (cas_n || mem_addr != cur_col) bad = 1'b1;
          end
        end
      end else begin
        hi_len = prev_ras ? hi_len + 1 : 1;
        if (!cas_n || data_gnt) chk(1'b0, "R5 strobes idle outside RAS", {cas_n, data_gnt}, 2);
      end
      if (!prev_ras && ras_n) begin
        if (run_ref) begin
          chk(run == RAS_CYC && !bad, "R3 RAS-only refresh row/length", run, RAS_CYC);
          if (exp_row == NROWS - 1) wraps++;
          exp_row = (exp_row + 1) % NROWS;
        end else begin
          chk(run == RAS_CYC && !bad, "R5 data cycle phases", run, RAS_CYC);
        end
      end
      prev_ras = ras_n;
    end
  end

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_data(input logic [8:0] r, input logic [8:0] c);
    @(negedge clk); #1;
    cur_row = r; cur_col = c;
    data_row = r; data_col = c; data_req = 1'b1;
    while (!data_gnt) begin @(negedge clk); #1; end
    data_req = 1'b0;
    while (!ras_n) begin @(negedge clk); #1; end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int tnom;
    int k;
    cur_row = '0; cur_col = '0; wraps = 0;
    tick_n(3);
    // R1: idle outputs during reset
    chk(ras_n && cas_n && !data_gnt && mem_addr == 0, "R1 reset outputs",
        {ras_n, cas_n, data_gnt}, 6);
    rst = 1'b0;

    // R2, R3, R4: quiet refreshes on a fixed grid
    quiet = 1'b1;
    tick_n(6 * P);
    chk(ref_cnt >= 5, "R2 refreshes with no traffic", ref_cnt, 5);
    quiet = 1'b0;

    // R5: table of data cycles with boundary addresses
    for (int i = 0; i < 8; i++) do_data(VEC[i][17:9], VEC[i][8:0]);

    // R8: refresh and data reach the idle arbiter on the same edge
    tick_n(2 * P);
    k = (cyc - anchor) / P + 1;
    tnom = anchor + k * P;
    if (tnom - cyc < 3) tnom += P;
    while (cyc < tnom - 2) begin @(negedge clk); #1; end
    cur_row = 9'd33; cur_col = 9'd444;
    data_row = 9'd33; data_col = 9'd444; data_req = 1'b1;
    while (ras_n) begin @(negedge clk); #1; end
    chk(!data_gnt, "R8 tie goes to refresh", data_gnt, 0);
    chk(cyc == tnom, "R8 tie refresh on time", cyc, tnom);
    while (!data_gnt) begin @(negedge clk); #1; end
    chk(data_gnt, "R8 data served after refresh", data_gnt, 1);
    data_req = 1'b0;
    while (!ras_n) begin @(negedge clk); #1; end

    // R7, R8, R4: continuous data demand across the row wrap
    cur_row = 9'd77; cur_col = 9'd300;
    data_row = 9'd77; data_col = 9'd300; data_req = 1'b1;
    tick_n(12000);
    data_req = 1'b0;
    tick_n(2 * P);
    chk(wraps >= 1, "R4 row wrap seen", wraps, 1);
    chk(ref_cnt >= NROWS + 1, "R7 refreshes kept under load", ref_cnt, NROWS + 1);

    // R1: reset in the middle of a data cycle
    data_row = 9'd5; data_col = 9'd6; cur_row = 9'd5; cur_col = 9'd6;
    data_req = 1'b1;
    while (!data_gnt) begin @(negedge clk); #1; end
    mon_en = 1'b0;
    rst = 1'b1;
    data_req = 1'b0;
    tick_n(1);
    chk(ras_n && cas_n && !data_gnt && mem_addr == 0, "R1 mid-cycle reset",
        {ras_n, cas_n, data_gnt}, 6);
    tick_n(2);
    rst = 1'b0;
    mon_en = 1'b1;
    quiet = 1'b1;
    tick_n(4 * P + 10);
    chk(ref_cnt >= 3, "R1 R4 refresh restarts from row 0", ref_cnt, 3);
    report();
  end
endmodule